// File: doc/BRIEF.md
# HDLC Receive Frame Length Supervisor

This block sits beside an HDLC receiver and counts the data bytes of each incoming frame. A start-of-frame pulse opens a frame and clears the count. Each byte strobe adds one to the count. An end-of-frame pulse closes the frame. Software supplies an enable bit and a 7-bit length code, and these two inputs set the largest frame it will accept. The limit is `(code + 1) * 32` bytes, which gives a range from 32 to 4096 bytes.

If the enable bit is set and a frame grows past its limit, the supervisor treats the frame as if the far end had aborted it. It raises the message-end interrupt and sets the abort flag. It then stops forwarding bytes and ignores the link until the next start of frame. The stored byte count stops one or two bytes above the limit. A genuine remote abort never leaves that signature, so software can tell a length violation apart from a real abort. A frame that closes at or under the limit gets an ordinary message-end interrupt with the abort flag clear. Software clears both flags with an acknowledge pulse.

Top module: `frm_len_sup`

## Requirements
- R1: After reset the byte count is 0, the interrupt and abort flags are 0, and no byte is forwarded.
- R2: A start-of-frame pulse makes the byte count 0 one cycle later and opens a frame. A byte strobe in the same cycle as the start pulse is not counted.
- R3: Inside an open frame, each byte strobe adds exactly one to the byte count in the following cycle. The strobe is forwarded on `byte_pass_o` in the same cycle, provided it does not violate the limit.
- R4: The limit is `(len_code_i + 1) * 32`. With `chk_en_i` = 1, the byte that takes the count to limit + 1 is a violation. That byte is not forwarded. One cycle later `msg_end_irq_o` and `abort_sts_o` are both 1.
- R5: After a violation no byte is forwarded. At most one further byte is counted, so the count holds at limit + 1 or limit + 2.
- R6: After a violation, end-of-frame pulses and byte strobes change nothing until the next start-of-frame. That start pulse restarts counting from 0.
- R7: A frame that ends with the count at or below the limit sets `msg_end_irq_o` one cycle after the end pulse and leaves `abort_sts_o` at 0. Byte strobes between the end pulse and the next start pulse do not change the count.
- R8: With `chk_en_i` = 0, a frame longer than the limit is counted and forwarded in full, and no abort is reported.
- R9: An `ack_i` pulse clears both flags one cycle later. A flag that is set in the same cycle as the acknowledge stays set.
- R10: Byte strobes outside any frame, that is after reset and before the first start pulse, are neither counted nor forwarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_vld_i | input | 1 | One received data byte |
| eof_i | input | 1 | End-of-frame pulse |
| chk_en_i | input | 1 | Length check enable |
| len_code_i | input | 7 | Length code; limit = (code+1)*32 bytes |
| ack_i | input | 1 | Software acknowledge; clears the flags |
| byte_pass_o | output | 1 | Byte strobe forwarded downstream |
| msg_end_irq_o | output | 1 | Message-end interrupt, held until acknowledged |
| abort_sts_o | output | 1 | Abort status flag |
| byte_cnt_o | output | 13 | Byte count of the current or last frame |

## Verification
Some rules are checked by the assertions on every cycle:
- a start pulse clears the count;
- each forwarded byte adds exactly one;
- the count stays frozen while no frame is open;
- nothing is forwarded once a frame has been dropped;
- the abort flag never rises without the interrupt;
- an acknowledge with no competing event clears both flags.

Other behaviour depends on the exact limit arithmetic across codes, and only the bench's sweeps can show it. That covers where the violation falls, the limit + 1 or + 2 count signature, and the boundary between a frame of exactly the limit and one byte more. It also covers the enable-off pass-through and the ordering of an acknowledge against a same-cycle set.

// File: rtl/frm_len_pkg.sv
package frm_len_pkg;
  localparam int unsigned CODE_W    = 7;
  localparam int unsigned BLK_SHIFT = 5;
  localparam int unsigned CNT_W     = CODE_W + BLK_SHIFT + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2
  } rx_state_e;
endpackage

// File: rtl/frm_len_limit.sv
module frm_len_limit #(
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned BLK_SHIFT = 5,
  parameter int unsigned CNT_W     = CODE_W + BLK_SHIFT + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  lim_p1_o,
  output logic [CNT_W-1:0]  lim_p2_o
);
  logic [CNT_W-1:0] blocks;
  logic [CNT_W-1:0] limit;

  // Block count is code + 1; limit is that many 2**BLK_SHIFT byte blocks.
  always_comb begin
    blocks   = CNT_W'(code_i) + CNT_W'(1);
    limit    = blocks << BLK_SHIFT;
    lim_p1_o = limit + CNT_W'(1);
    lim_p2_o = limit + CNT_W'(2);
  end
endmodule

// File: rtl/frm_byte_ctr.sv
module frm_byte_ctr #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/frm_rx_ctrl.sv
module frm_rx_ctrl
  import frm_len_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             sof_i,
  input  logic             byte_vld_i,
  input  logic             eof_i,
  input  logic             ack_i,
  input  logic             chk_en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] lim_p1_i,
  input  logic [CNT_W-1:0] lim_p2_i,
  output logic             clr_o,
  output logic             inc_o,
  output logic             pass_o,
  output logic             irq_o,
  output logic             abort_o,
  output rx_state_e        state_o
);
  rx_state_e state_q, state_d;
  logic      irq_q, irq_d;
  logic      ab_q, ab_d;
  logic      set_irq, set_ab;
  logic      viol;
  logic [CNT_W:0] cnt_next_w;

  // Violation: this byte brings the count to limit+1 (or beyond, if the
  // check was enabled late in a frame).
  always_comb begin
    cnt_next_w = {1'b0, cnt_i} + {{CNT_W{1'b0}}, 1'b1};
    viol       = chk_en_i && (cnt_next_w >= {1'b0, lim_p1_i});
  end

  always_comb begin
    state_d = state_q;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    pass_o  = 1'b0;
    set_irq = 1'b0;
    set_ab  = 1'b0;
    if (sof_i) begin
      clr_o   = 1'b1;
      state_d = ST_RECV;
    end else begin
      unique case (state_q)
        ST_RECV: begin
          if (byte_vld_i) begin
            inc_o = 1'b1;
            if (viol) begin
              set_irq = 1'b1;
              set_ab  = 1'b1;
              state_d = ST_DROP;
            end else begin
              pass_o = 1'b1;
            end
          end
          if (eof_i && !(byte_vld_i && viol)) begin
            set_irq = 1'b1;
            state_d = ST_IDLE;
          end
        end
        ST_DROP: begin
          // one extra byte may be counted, then the count saturates
          if (byte_vld_i && (cnt_i < lim_p2_i)) inc_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // Set wins over acknowledge in the same cycle.
  always_comb begin
    irq_d = set_irq | (irq_q & ~ack_i);
    ab_d  = set_ab  | (ab_q  & ~ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
      ab_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      ab_q    <= ab_d;
    end
  end

  assign irq_o   = irq_q;
  assign abort_o = ab_q;
  assign state_o = state_q;
endmodule

// File: rtl/frm_len_sup.sv
module frm_len_sup
  import frm_len_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              sof_i,
  input  logic              byte_vld_i,
  input  logic              eof_i,
  input  logic              chk_en_i,
  input  logic [CODE_W-1:0] len_code_i,
  input  logic              ack_i,
  output logic              byte_pass_o,
  output logic              msg_end_irq_o,
  output logic              abort_sts_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [CNT_W-1:0] lim_p1, lim_p2, cnt;
  logic             ctr_clr, ctr_inc;
  rx_state_e        state_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  frm_len_limit #(.CODE_W(CODE_W), .BLK_SHIFT(BLK_SHIFT), .CNT_W(CNT_W)) u_limit (
    .code_i   (len_code_i),
    .lim_p1_o (lim_p1),
    .lim_p2_o (lim_p2)
  );

  frm_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .clr_i   (ctr_clr),
    .inc_i   (ctr_inc),
    .cnt_o   (cnt)
  );

  frm_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_n_i    (rst_sync_n),
    .sof_i      (sof_i),
    .byte_vld_i (byte_vld_i),
    .eof_i      (eof_i),
    .ack_i      (ack_i),
    .chk_en_i   (chk_en_i),
    .cnt_i      (cnt),
    .lim_p1_i   (lim_p1),
    .lim_p2_i   (lim_p2),
    .clr_o      (ctr_clr),
    .inc_o      (ctr_inc),
    .pass_o     (byte_pass_o),
    .irq_o      (msg_end_irq_o),
    .abort_o    (abort_sts_o),
    .state_o    (state_q)
  );

  assign byte_cnt_o = cnt;
endmodule

// File: rtl/frm_len_sup_chk.sv
module frm_len_sup_chk
  import frm_len_pkg::*;
(
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             sof_i,
  input logic             byte_vld_i,
  input logic             eof_i,
  input logic             ack_i,
  input logic             pass_i,
  input logic             irq_i,
  input logic             abort_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       state_i
);
  p_sof_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sof_i |=> (cnt_i == '0));

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pass_i |=> (cnt_i == $past(cnt_i) + CNT_W'(1)));

  p_abort_with_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(abort_i) |-> irq_i);

  p_no_pass_dropped_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_i == ST_DROP) |-> !pass_i);

  p_idle_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((state_i == ST_IDLE) && !sof_i) |=> $stable(cnt_i));

  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ack_i && !byte_vld_i && !eof_i && !sof_i) |=> (!irq_i && !abort_i));
endmodule

bind frm_len_sup frm_len_sup_chk u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_sync_n),
  .sof_i      (sof_i),
  .byte_vld_i (byte_vld_i),
  .eof_i      (eof_i),
  .ack_i      (ack_i),
  .pass_i     (byte_pass_o),
  .irq_i      (msg_end_irq_o),
  .abort_i    (abort_sts_o),
  .cnt_i      (byte_cnt_o),
  .state_i    (state_q)
);

// File: tb/frm_len_sup_test.sv
module frm_len_sup_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sof, vld, eof, en, ack;
  logic [6:0]  code;
  logic        pass, irq, abrt;
  logic [12:0] cnt;
  int          n_chk = 0, n_bad = 0, n_pass = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  frm_len_sup uut (
    .clk_i(clk), .rst_n_i(rst_n), .sof_i(sof), .byte_vld_i(vld), .eof_i(eof),
    .chk_en_i(en), .len_code_i(code), .ack_i(ack), .byte_pass_o(pass),
    .msg_end_irq_o(irq), .abort_sts_o(abrt), .byte_cnt_o(cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge and tally forwarded bytes.
  task automatic cyc(input bit s, input bit v, input bit e, input bit a);
    @(negedge clk);
    sof = s; vld = v; eof = e; ack = a;
    #0.5;
    if (pass) n_pass++;
  endtask

  task automatic settle();
    @(negedge clk);
    sof = 0; vld = 0; eof = 0; ack = 0;
  endtask

  // Frame of nb bytes; checks count, flags and forwarded bytes.
  task automatic frame(input int nb, input int lim, input bit chk_on, input string tag);
    int exp_cnt, exp_pass;
    bit viol;
    viol = chk_on && (nb > lim);
    exp_cnt  = viol ? ((nb >= lim + 2) ? lim + 2 : lim + 1) : nb;
    exp_pass = viol ? lim : nb;
    n_pass = 0;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < nb; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    settle();
    check({tag, " count"}, cnt, exp_cnt);
    check({tag, " forwarded"}, n_pass, exp_pass);
    check({tag, " irq"}, irq, 1);
    check({tag, " abort"}, abrt, viol);
    cyc(0, 0, 0, 1);
    settle();
    check("R9 ack clears irq", irq, 0);
    check("R9 ack clears abort", abrt, 0);
  endtask

  initial begin
    sof = 0; vld = 0; eof = 0; ack = 0; en = 1; code = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 reset count", cnt, 0);
    check("R1 reset irq", irq, 0);
    check("R1 reset abort", abrt, 0);
    check("R1 reset pass", pass, 0);

    n_pass = 0;
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); settle();
    check("R10 idle bytes not counted", cnt, 0);
    check("R10 idle bytes not forwarded", n_pass, 0);

    cyc(1, 1, 0, 0); settle();
    check("R2 byte with sof not counted", cnt, 0);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); settle();
    check("R3 three bytes", cnt, 3);
    cyc(1, 0, 0, 0); settle();
    check("R2 sof clears", cnt, 0);
    cyc(0, 0, 1, 0); settle(); cyc(0, 0, 0, 1); settle();

    // Sweep codes 0..15: exact limit, limit+1, and long overrun.
    for (int c = 0; c < 16; c++) begin
      int lim;
      code = 7'(c);
      lim = (c + 1) * 32;
      frame(lim, lim, 1, "R7 exact limit");
      frame(lim + 1, lim, 1, "R4 limit+1");
      frame(lim + 7, lim, 1, "R5 overrun");
    end

    code = 7'd127;
    frame(4099, 4096, 1, "R4 max code");

    code = 7'd3; en = 0;
    frame(133, 128, 0, "R8 check disabled");
    en = 1;

    // R6: events after a violation are ignored until SOF.
    code = 7'd0;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 34; i++) cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 1); settle();
    check("R6 acked in drop", irq, 0);
    cyc(0, 0, 1, 0); cyc(0, 1, 0, 0); settle();
    check("R6 eof ignored after violation", irq, 0);
    check("R6 count held after violation", cnt, 34);
    cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); settle();
    check("R6 sof restarts", cnt, 1);

    // R7: bytes after normal end ignored; R9 set beats same-cycle ack.
    n_pass = 0;
    cyc(0, 0, 1, 1); settle();
    check("R9 set wins over ack", irq, 1);
    check("R7 normal end no abort", abrt, 0);
    cyc(0, 1, 0, 0); cyc(0, 1, 0, 0); settle();
    check("R7 bytes after eof ignored", cnt, 1);
    check("R7 bytes after eof not forwarded", n_pass, 0);
    cyc(0, 0, 0, 1); settle();

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule